// File: doc/BRIEF.md
# Memory-Aware CTA Throttle Controller

This block sits beside one compute core and decides how many thread blocks (CTAs) the core may hold at once. On every clock cycle it receives two flags: one saying the core had nothing to issue, and one saying its warps were stalled on memory data. It counts both kinds of cycle over a fixed sampling window. At the end of each window it moves the resident-CTA limit down by one when memory stalls dominated, up by one when idle cycles dominated, and otherwise leaves it where it is.

The dispatcher tells the controller how many CTAs are resident at the moment. The controller answers with a grant flag for new assignments and a pause mask over the resident slots. Slot 0 holds the oldest resident CTA and higher slots hold younger ones. Each slot at or above the current limit is marked for pausing, so the youngest CTAs are paused first when the limit drops below the resident count.

Top module: `cta_throttle_ctrl`

## Requirements
- R1: After reset, the limit equals MAX_CTAS/2 (at least 1) and both window counters start from zero. An asserted reset in the middle of a window returns the limit to that value.
- R2: A window is WIN_LEN consecutive cycles, counted from the first rising edge after reset. The limit changes only on the last edge of a window, and the new value is visible right after that edge.
- R3: If more than MEM_HI cycles of a window had the memory-wait flag set, the limit drops by one.
- R4: If more than IDLE_HI cycles of a window had the idle flag set, and R3 did not apply, the limit rises by one.
- R5: If a window meets neither threshold (including counts exactly equal to a threshold), the limit stays the same.
- R6: If both thresholds are exceeded in the same window, the memory rule wins and the limit drops.
- R7: The limit always stays between 1 and MAX_CTAS inclusive. A drop at 1 and a rise at MAX_CTAS both leave it unchanged.
- R8: accept_o is 1 exactly when resident_i is less than the current limit.
- R9: pause_mask_o bit i is 1 exactly when limit <= i < resident_i. Bit 0 is the oldest resident CTA.
- R10: Both counters clear at every window boundary, so the counts from one window never carry into the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_i | input | 1 | Core had nothing to issue this cycle |
| mem_wait_i | input | 1 | Core warps were stalled on memory this cycle |
| resident_i | input | CW | Number of CTAs resident now, from the dispatcher |
| cta_limit_o | output | CW | Current resident-CTA limit |
| accept_o | output | 1 | Dispatcher may assign a new CTA |
| pause_mask_o | output | MAX_CTAS | Slots to pause, where slot 0 is the oldest |

## Verification
The main function is driven with windows that are memory-heavy, idle-heavy, balanced exactly at both thresholds, and heavy in both at once. These windows separate the decrement rule, the increment rule, the hold case and the priority between the two rules. Runs of repeated memory-heavy and idle-heavy windows push the limit to both clamps. At each step the resident count is varied so that the grant flag and the position of the pause bits are seen above, at and below the limit. Two consecutive windows, each with memory stalls just below the threshold, show whether the counters clear between windows. A reset in the middle of a window shows that the limit returns to its starting value.

// File: rtl/cta_thr_pkg.sv
`timescale 1ns/1ps
package cta_thr_pkg;

    typedef enum logic [1:0] {
        ADJ_HOLD = 2'd0,
        ADJ_DOWN = 2'd1,
        ADJ_UP   = 2'd2
    } adj_e;

    // Memory pressure takes priority over idleness.
    function automatic adj_e classify(input int unsigned idle_n,
                                      input int unsigned mem_n,
                                      input int unsigned idle_hi,
                                      input int unsigned mem_hi);
        if (mem_n > mem_hi)        return ADJ_DOWN;
        else if (idle_n > idle_hi) return ADJ_UP;
        else                       return ADJ_HOLD;
    endfunction

endpackage

// File: rtl/cta_win_stats.sv
`timescale 1ns/1ps
module cta_win_stats #(
    parameter int WIN_LEN = 16,
    parameter int CNTW    = 5,
    parameter int POSW    = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            idle_i,
    input  logic            mem_i,
    output logic            done_o,
    output logic [CNTW-1:0] idle_sum_o,
    output logic [CNTW-1:0] mem_sum_o
);

    typedef struct packed {
        logic [POSW-1:0] pos;
        logic [CNTW-1:0] idle;
        logic [CNTW-1:0] mem;
    } stat_t;

    stat_t st_d, st_q;

    localparam logic [POSW-1:0] LAST_POS = POSW'(WIN_LEN - 1);

    always_comb begin
        st_d       = st_q;
        idle_sum_o = st_q.idle + {{(CNTW-1){1'b0}}, idle_i};
        mem_sum_o  = st_q.mem  + {{(CNTW-1){1'b0}}, mem_i};
        done_o     = (st_q.pos == LAST_POS);
        if (done_o) begin
            st_d.pos  = '0;
            st_d.idle = '0;
            st_d.mem  = '0;
        end else begin
            st_d.pos  = st_q.pos + 1'b1;
            st_d.idle = idle_sum_o;
            st_d.mem  = mem_sum_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R10
    win_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(st_q.idle) <= 32'(st_q.pos)) && (32'(st_q.mem) <= 32'(st_q.pos)));

    // R2
    win_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (st_q.pos == '0) && (st_q.idle == '0) && (st_q.mem == '0));

endmodule

// File: rtl/cta_limit_ctl.sv
`timescale 1ns/1ps
module cta_limit_ctl
    import cta_thr_pkg::*;
#(
    parameter int MAX_CTAS = 8,
    parameter int IDLE_HI  = 8,
    parameter int MEM_HI   = 8,
    parameter int CNTW     = 5,
    parameter int CW       = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            done_i,
    input  logic [CNTW-1:0] idle_sum_i,
    input  logic [CNTW-1:0] mem_sum_i,
    output logic [CW-1:0]   lim_o
);

    localparam int            HALF    = MAX_CTAS / 2;
    localparam logic [CW-1:0] RST_LIM = CW'((HALF < 1) ? 1 : HALF);
    localparam logic [CW-1:0] TOP_LIM = CW'(MAX_CTAS);

    logic [CW-1:0] lim_d, lim_q;
    adj_e          adj;

    always_comb begin
        adj   = classify(32'(idle_sum_i), 32'(mem_sum_i), IDLE_HI, MEM_HI);
        lim_d = lim_q;
        if (done_i) begin
            case (adj)
                ADJ_DOWN: if (lim_q > CW'(1))  lim_d = lim_q - 1'b1;
                ADJ_UP:   if (lim_q < TOP_LIM) lim_d = lim_q + 1'b1;
                default:  lim_d = lim_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lim_q <= RST_LIM;
        else        lim_q <= lim_d;
    end

    assign lim_o = lim_q;

    // R7
    limit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_q >= CW'(1)) && (lim_q <= TOP_LIM));

    // R2
    limit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable(lim_q));

    // R3
    limit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> (lim_q == $past(lim_q)) || (lim_q == $past(lim_q) + 1'b1)
                   || (lim_q + 1'b1 == $past(lim_q)));

endmodule

// File: rtl/cta_pause_map.sv
`timescale 1ns/1ps
module cta_pause_map #(
    parameter int MAX_CTAS = 8,
    parameter int CW       = 4
) (
    input  logic [CW-1:0]       lim_i,
    input  logic [CW-1:0]       resident_i,
    output logic [MAX_CTAS-1:0] mask_o,
    output logic                accept_o
);

    for (genvar g = 0; g < MAX_CTAS; g++) begin : g_slot
        localparam logic [CW-1:0] SLOT = CW'(g);
        assign mask_o[g] = (SLOT >= lim_i) && (SLOT < resident_i);
    end

    assign accept_o = (resident_i < lim_i);

endmodule

// File: rtl/cta_throttle_ctrl.sv
`timescale 1ns/1ps
module cta_throttle_ctrl #(
    parameter int  MAX_CTAS = 8,
    parameter int  WIN_LEN  = 16,
    parameter int  IDLE_HI  = 8,
    parameter int  MEM_HI   = 8,
    localparam int CW       = $clog2(MAX_CTAS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                idle_i,
    input  logic                mem_wait_i,
    input  logic [CW-1:0]       resident_i,
    output logic [CW-1:0]       cta_limit_o,
    output logic                accept_o,
    output logic [MAX_CTAS-1:0] pause_mask_o
);

    localparam int CNTW = $clog2(WIN_LEN + 1);
    localparam int POSW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;

    logic            win_done;
    logic [CNTW-1:0] idle_sum;
    logic [CNTW-1:0] mem_sum;

    cta_win_stats #(
        .WIN_LEN (WIN_LEN),
        .CNTW    (CNTW),
        .POSW    (POSW)
    ) u_stats (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle_i     (idle_i),
        .mem_i      (mem_wait_i),
        .done_o     (win_done),
        .idle_sum_o (idle_sum),
        .mem_sum_o  (mem_sum)
    );

    cta_limit_ctl #(
        .MAX_CTAS (MAX_CTAS),
        .IDLE_HI  (IDLE_HI),
        .MEM_HI   (MEM_HI),
        .CNTW     (CNTW),
        .CW       (CW)
    ) u_limit (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_i     (win_done),
        .idle_sum_i (idle_sum),
        .mem_sum_i  (mem_sum),
        .lim_o      (cta_limit_o)
    );

    cta_pause_map #(
        .MAX_CTAS (MAX_CTAS),
        .CW       (CW)
    ) u_map (
        .lim_i      (cta_limit_o),
        .resident_i (resident_i),
        .mask_o     (pause_mask_o),
        .accept_o   (accept_o)
    );

    // R9
    pause_grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|pause_mask_o) |-> !accept_o);

    // R8
    grant_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> (cta_limit_o > resident_i));

endmodule

// File: tb/sim_cta_throttle_ctrl.sv
`timescale 1ns/1ps
module sim_cta_throttle_ctrl;

    localparam int MAX = 8;
    localparam int WIN = 16;
    localparam int CW  = $clog2(MAX + 1);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           idle_i = 1'b0;
    logic           mem_i = 1'b0;
    logic [CW-1:0]  res_i = '0;
    logic [CW-1:0]  lim_o;
    logic           acc_o;
    logic [MAX-1:0] mask_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    cta_throttle_ctrl #(.MAX_CTAS(MAX), .WIN_LEN(WIN), .IDLE_HI(8), .MEM_HI(8)) u0 (
        .clk(clk), .rst_n(rst_n), .idle_i(idle_i), .mem_wait_i(mem_i),
        .resident_i(res_i), .cta_limit_o(lim_o), .accept_o(acc_o),
        .pause_mask_o(mask_o)
    );

    // columns: idle cycles, mem cycles, resident, exp limit, exp accept, exp mask
    localparam int NV = 15;
    localparam int VEC [NV][6] = '{
        '{ 0, 12, 4, 3, 0, 'h08},  // R3 R9
        '{ 0, 12, 4, 2, 0, 'h0C},  // R3 R9
        '{ 0,  9, 2, 1, 0, 'h02},  // R3
        '{ 0, 16, 1, 1, 0, 'h00},  // R7 floor
        '{ 8,  8, 0, 1, 1, 'h00},  // R5 at thresholds
        '{ 9,  0, 1, 2, 1, 'h00},  // R4
        '{12, 12, 3, 1, 0, 'h06},  // R6
        '{16,  0, 8, 2, 0, 'hFC},  // R4 R9
        '{16,  0, 2, 3, 1, 'h00},  // R8
        '{16,  0, 8, 4, 0, 'hF0},
        '{16,  0, 4, 5, 1, 'h00},
        '{16,  0, 8, 6, 0, 'hC0},
        '{16,  0, 7, 7, 0, 'h00},  // R8 equal
        '{16,  0, 8, 8, 0, 'h00},
        '{16,  0, 5, 8, 1, 'h00}   // R7 cap
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req, input int el, input int ea, input int em);
        check({req, " limit"}, int'(lim_o), el);
        check({req, " accept"}, int'(acc_o), ea);
        check({req, " mask"}, int'(mask_o), em);
    endtask

    // starts and ends at a negedge; exactly WIN rising edges pass
    task automatic run_window(input int n_idle, input int n_mem);
        for (int k = 0; k < WIN; k++) begin
            idle_i = (k < n_idle);
            mem_i  = (k < n_mem);
            @(negedge clk);
        end
        idle_i = 1'b0;
        mem_i  = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        res_i = 0;
        #1;
        check_all("R1 reset", 4, 1, 'h00);
        res_i = 6;
        #1;
        check_all("R1 R9 reset resident6", 4, 0, 'h30);
        @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            run_window(VEC[v][0], VEC[v][1]);
            res_i = CW'(VEC[v][2]);
            #1;
            check_all($sformatf("R2 vec%0d", v), VEC[v][3], VEC[v][4], VEC[v][5]);
        end

        // R2: limit does not move inside a window
        for (int k = 0; k < 8; k++) begin
            mem_i = 1'b1;
            @(negedge clk);
        end
        check("R2 mid-window hold", int'(lim_o), 8);
        mem_i = 1'b0;
        rst_n = 1'b0;
        res_i = 0;
        #1;
        check_all("R1 mid-window reset", 4, 1, 'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: 5 + 5 memory cycles split across windows must not add up
        run_window(0, 5);
        #1;
        check("R10 first window hold", int'(lim_o), 4);
        run_window(0, 5);
        #1;
        check("R10 counters cleared", int'(lim_o), 4);

        // R8 / R9 at the reset limit after windows
        res_i = 6;
        #1;
        check_all("R8 R9 resident above limit", 4, 0, 'h30);
        res_i = 3;
        #1;
        check_all("R8 resident below limit", 4, 1, 'h00);

        finish_run();
    end

endmodule